// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

The controller serves up to 176 general-purpose pins, grouped into banks of 32. A 32-bit word port with byte addresses reaches every register. Each bank has seven registers: a read-only pin level, a direction register, write-one-to-set and write-one-to-clear strobes for the output latch, rising and falling edge enables, and a sticky edge-status register. Each bank also has an interrupt mask.

Each pin input passes through a two-flop synchronizer. An edge is a change between the synchronized value and its value on the previous cycle. When an edge is enabled, it latches a status bit. The single interrupt output is a level: it stays high while any latched status bit is unmasked. A parameter selects pins whose direction sense is inverted. For those pins a direction bit of 0 makes the pin drive.

Top module: `banked_gpio`

## Requirements
- R1: Bank n has its base at byte address 4*n for n of 0 to 2, and at 0x100 + 4*(n-3) for n of 3 to 5. Each register sits at a fixed byte offset from its bank base: level 0x00, direction 0x0C, set 0x18, clear 0x24, rising enable 0x30, falling enable 0x3C, edge status 0x48, interrupt mask 0x9C. A write through one address changes no other bank or register.
- R2: The level register returns each pin as seen through a two-flop synchronizer. Writes to the level register have no effect.
- R3: A direction bit of 1 sets `pin_oe` for that pin. For pins whose bit is set in `DIR_INVERT`, a direction bit of 0 sets `pin_oe` instead. The direction register reads back the value last written.
- R4: Writing the set register drives high each output whose data bit is 1. Writing the clear register drives low each output whose data bit is 1. A 0 bit, or any write elsewhere, leaves `pin_out` unchanged.
- R5: A status bit becomes 1 when its pin rises while its rising enable is 1, or falls while its falling enable is 1. An edge with its enable at 0 latches nothing.
- R6: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R7: If a new enabled edge and a write-one-to-clear reach the same status bit in the same cycle, the bit stays 1.
- R8: `irq` is the OR over all banks of (status AND mask). A status bit whose mask bit is 0 does not raise `irq`.
- R9: Once high, `irq` stays high until software clears the status bit or its mask bit.
- R10: After reset, `pin_out` and `pin_oe` are 0, `irq` is 0, and the enables, status and masks are 0. The direction register reads 0 for normal pins and 1 for inverted pins, so every pin is an input.
- R11: Bits of the last bank above `NUM_PINS` read 0. Addresses that map to no register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register accessed |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch values |
| pin_oe | output | NUM_PINS | Per-pin output enable |
| irq | output | 1 | Level interrupt for unmasked latched edges |

## Verification
The assertions assume that `bus_wr` is held low through reset. They also assume that `NUM_PINS` is at least 32, because the set and clear properties look at the bits of bank 0. The interrupt-hold property relies on status and mask changing only through bus writes, so it is checked only in cycles with no write. The bench drives the bus and the pins only at falling clock edges and keeps the write strobe low during reset. It times the clear in the edge-collision scenario to land on the exact cycle in which the synchronized edge is latched.

// File: rtl/banked_gpio.sv
module banked_gpio #(
  parameter int                  NUM_PINS   = 176,
  parameter logic [NUM_PINS-1:0] DIR_INVERT = '0,
  parameter int                  ADDR_W     = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq
);

  localparam int NB = (NUM_PINS + 31) / 32;
  localparam int W  = NB * 32;

  localparam int OFF_LVL = 'h00;
  localparam int OFF_DIR = 'h0C;
  localparam int OFF_SET = 'h18;
  localparam int OFF_CLR = 'h24;
  localparam int OFF_REN = 'h30;
  localparam int OFF_FEN = 'h3C;
  localparam int OFF_STS = 'h48;
  localparam int OFF_MSK = 'h9C;

  function automatic logic [W-1:0] f_impl();
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[i] = (i < NUM_PINS);
    return m;
  endfunction

  function automatic logic [W-1:0] f_inv();
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_PINS; i++) m[i] = DIR_INVERT[i];
    return m;
  endfunction

  localparam logic [W-1:0] IMPL = f_impl();
  localparam logic [W-1:0] INVW = f_inv();

  logic [W-1:0] pin_w;
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic [W-1:0] out_w, oe_w;
  logic [31:0]  rd_v [NB];
  logic [NB-1:0] irq_v;

  assign pin_w = W'(pin_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_w & IMPL;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam int          BASE  = (b < 3) ? b * 4 : 'h100 + (b - 3) * 4;
    localparam logic [31:0] VMASK = IMPL[b*32 +: 32];
    localparam logic [31:0] VINV  = INVW[b*32 +: 32];

    logic [31:0] dir_q, out_q, ren_q, fen_q, sts_q, msk_q;
    logic [31:0] lvl, prv, edges;
    logic hit_lvl, hit_dir, hit_set, hit_clr, hit_ren, hit_fen, hit_sts, hit_msk;

    assign hit_lvl = bus_addr == ADDR_W'(BASE + OFF_LVL);
    assign hit_dir = bus_addr == ADDR_W'(BASE + OFF_DIR);
    assign hit_set = bus_addr == ADDR_W'(BASE + OFF_SET);
    assign hit_clr = bus_addr == ADDR_W'(BASE + OFF_CLR);
    assign hit_ren = bus_addr == ADDR_W'(BASE + OFF_REN);
    assign hit_fen = bus_addr == ADDR_W'(BASE + OFF_FEN);
    assign hit_sts = bus_addr == ADDR_W'(BASE + OFF_STS);
    assign hit_msk = bus_addr == ADDR_W'(BASE + OFF_MSK);

    assign lvl   = sync_q[b*32 +: 32];
    assign prv   = prev_q[b*32 +: 32];
    assign edges = (lvl & ~prv & ren_q) | (~lvl & prv & fen_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q <= VINV;
        out_q <= '0;
        ren_q <= '0;
        fen_q <= '0;
        sts_q <= '0;
        msk_q <= '0;
      end else begin
        if (bus_wr && hit_dir) dir_q <= bus_wdata & VMASK;
        if (bus_wr && hit_set) out_q <= out_q | (bus_wdata & VMASK);
        if (bus_wr && hit_clr) out_q <= out_q & ~bus_wdata;
        if (bus_wr && hit_ren) ren_q <= bus_wdata & VMASK;
        if (bus_wr && hit_fen) fen_q <= bus_wdata & VMASK;
        if (bus_wr && hit_msk) msk_q <= bus_wdata & VMASK;
        sts_q <= ((bus_wr && hit_sts) ? (sts_q & ~bus_wdata) : sts_q) | edges;
      end
    end

    always_comb begin
      rd_v[b] = '0;
      if (hit_lvl) rd_v[b] = lvl;
      if (hit_dir) rd_v[b] = dir_q;
      if (hit_ren) rd_v[b] = ren_q;
      if (hit_fen) rd_v[b] = fen_q;
      if (hit_sts) rd_v[b] = sts_q;
      if (hit_msk) rd_v[b] = msk_q;
    end

    assign out_w[b*32 +: 32] = out_q;
    assign oe_w[b*32 +: 32]  = (dir_q ^ VINV) & VMASK;
    assign irq_v[b]          = |(sts_q & msk_q);
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NB; b++) bus_rdata = bus_rdata | rd_v[b];
  end

  assign pin_out = out_w[NUM_PINS-1:0];
  assign pin_oe  = oe_w[NUM_PINS-1:0];
  assign irq     = |irq_v;

endmodule

// File: rtl/banked_gpio_checker.sv
module banked_gpio_checker #(
  parameter int NUM_PINS = 176,
  parameter int ADDR_W   = 9
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_wr,
  input logic [31:0]         bus_wdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                irq
);

  a_r4_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h18)) |=>
      ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  a_r4_clear_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'('h24)) |=>
      ((pin_out[31:0] & $past(bus_wdata)) == 32'h0));

  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_out));

  a_r3_oe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(pin_oe));

  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !bus_wr) |=> irq);

  a_r10_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && !irq));

endmodule

bind banked_gpio banked_gpio_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/tb_banked_gpio.sv
`timescale 1ns/1ps
module tb_banked_gpio;
  localparam int NP = 176;
  localparam logic [NP-1:0] INV = NP'(4'hF) << 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [8:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  banked_gpio #(.NUM_PINS(NP), .DIR_INVERT(INV), .ADDR_W(9)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #2.5 clk = ~clk;

  localparam int LVL = 'h00, DIR = 'h0C, SET = 'h18, CLR = 'h24;
  localparam int REN = 'h30, FEN = 'h3C, STS = 'h48, MSK = 'h9C;

  function automatic logic [8:0] ra(int bank, int off);
    int base;
    base = (bank < 3) ? bank * 4 : 'h100 + (bank - 3) * 4;
    return 9'(base + off);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R10 pin_out", 32'(pin_out == '0), 1);
    chk("R10 pin_oe", 32'(pin_oe == '0), 1);
    chk("R10 irq", 32'(irq), 0);
    rd(ra(0, DIR), d); chk("R10 dir bank0", d, 32'h0);
    rd(ra(1, DIR), d); chk("R10 dir bank1 inverted", d, 32'h0000_0F00);
    rd(ra(0, STS), d); chk("R10 status", d, 32'h0);
    rd(ra(0, MSK), d); chk("R10 mask", d, 32'h0);
  endtask

  task automatic t_addr();
    logic [31:0] d;
    wr(ra(4, REN), 32'hA5A5_0001);
    rd(9'h134, d);      chk("R1 bank4 rise enable", d, 32'hA5A5_0001);
    rd(ra(1, REN), d);  chk("R1 bank1 untouched", d, 32'h0);
    rd(ra(4, FEN), d);  chk("R1 bank4 fall untouched", d, 32'h0);
    wr(9'h014, 32'h1234_5678);
    rd(ra(2, DIR), d);  chk("R1 bank2 direction", d, 32'h1234_5678);
    wr(ra(4, REN), 32'h0);
    wr(ra(2, DIR), 32'h0);
  endtask

  task automatic t_setclr();
    wr(ra(0, SET), 32'h0000_F0F0);
    chk("R4 set", pin_out[31:0], 32'h0000_F0F0);
    wr(ra(0, CLR), 32'h0000_3000);
    chk("R4 clear", pin_out[31:0], 32'h0000_C0F0);
    wr(ra(0, SET), 32'h0);
    chk("R4 zero set no change", pin_out[31:0], 32'h0000_C0F0);
    wr(ra(0, DIR), 32'hFFFF_FFFF);
    wr(ra(0, DIR), 32'h0);
    chk("R4 other write no change", pin_out[31:0], 32'h0000_C0F0);
    wr(ra(3, SET), 32'h1);
    chk("R4 bank3 set", 32'(pin_out[96]), 1);
    chk("R4 bank0 kept", pin_out[31:0], 32'h0000_C0F0);
  endtask

  task automatic t_dir();
    wr(ra(0, DIR), 32'h0000_00FF);
    chk("R3 normal oe", pin_oe[31:0], 32'h0000_00FF);
    wr(ra(1, DIR), 32'h0000_0F00);
    chk("R3 inverted at 1 is input", pin_oe[63:32], 32'h0);
    wr(ra(1, DIR), 32'h0000_0001);
    chk("R3 inverted at 0 drives", pin_oe[63:32], 32'h0000_0F01);
    wr(ra(1, DIR), 32'h0000_0F00);
    wr(ra(0, DIR), 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); pin_in[70] = 1'b1;
    settle(3);
    rd(ra(2, LVL), d); chk("R2 level bit 6", d, 32'h0000_0040);
    wr(ra(2, LVL), 32'h0);
    rd(ra(2, LVL), d); chk("R2 level write ignored", d, 32'h0000_0040);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    @(negedge clk); pin_in[5] = 1'b1;
    settle(4);
    wr(ra(0, MSK), 32'hFFFF_FFFF);
    wr(ra(0, REN), 32'h0000_0008);
    @(negedge clk); pin_in[5] = 1'b0; pin_in[3] = 1'b1;
    settle(4);
    rd(ra(0, STS), d); chk("R5 rise latched, unenabled fall ignored", d, 32'h0000_0008);
    chk("R8 irq raised", 32'(irq), 1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(ra(0, STS), 32'h0);
    rd(ra(0, STS), d); chk("R6 write 0 keeps", d, 32'h0000_0008);
    chk("R9 irq held", 32'(irq), 1);
    wr(ra(0, STS), 32'h0000_0008);
    rd(ra(0, STS), d); chk("R6 write 1 clears", d, 32'h0);
    chk("R9 irq dropped", 32'(irq), 0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(ra(0, MSK), 32'h0);
    wr(ra(0, FEN), 32'h0000_0008);
    @(negedge clk); pin_in[3] = 1'b0;
    settle(4);
    rd(ra(0, STS), d); chk("R5 fall latched", d, 32'h0000_0008);
    chk("R8 masked no irq", 32'(irq), 0);
    wr(ra(0, MSK), 32'h0000_0008);
    chk("R8 unmasked irq", 32'(irq), 1);
    wr(ra(0, STS), 32'h0000_0008);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(ra(0, REN), 32'h0000_0008);
    @(negedge clk); pin_in[3] = 1'b1;
    @(negedge clk);
    wr(ra(0, STS), 32'h0000_0008);
    rd(ra(0, STS), d); chk("R7 edge beats clear", d, 32'h0000_0008);
    chk("R7 irq stays", 32'(irq), 1);
    wr(ra(0, STS), 32'h0000_0008);
    rd(ra(0, STS), d); chk("R6 clear after race", d, 32'h0);
  endtask

  task automatic t_last();
    logic [31:0] d;
    wr(ra(5, REN), 32'hFFFF_FFFF);
    rd(9'h138, d); chk("R11 last bank upper bits", d, 32'h0000_FFFF);
    rd(9'h060, d); chk("R11 unmapped reads 0", d, 32'h0);
    rd(9'h1F0, d); chk("R11 unmapped high reads 0", d, 32'h0);
  endtask

  initial begin
    settle(4);
    rst_n = 1'b1;
    settle(2);
    t_reset();
    t_addr();
    t_setclr();
    t_dir();
    t_level();
    t_edge();
    t_w1c();
    t_mask();
    t_race();
    t_last();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule